// File: doc/BRIEF.md
# Opcode Decode Line Matcher

This block is the structured decode array of an 8-bit processor core. It receives the instruction register and a one-hot timing state that marks the current cycle of the instruction. It raises one output bit for each decode line in a parameter table. A line fires when three conditions hold together:

- Its pattern over instruction bits 7..2 matches, with each of these bits required to be 1, required to be 0, or ignored.
- The group it requires is active.
- The timing state shows the cycle it requires.

Instruction bits 1..0 are never compared directly. They are turned into three group signals first. The value 11 in those bits turns on groups 1 and 2 at the same time, so an opcode in that column fires the lines of both neighbouring opcodes.

The table is a parameter array, and a line's bit position in the output is its position in the table. The default table is a representative subset that includes the accumulator-load, X-load/store and transfer lines. Any of the three conditions of a line can be a don't-care. The output is combinational by default and can be registered with a parameter. All pins are plain control pins with no handshake, because the block only decodes a level-held state.

Top module: `opdec_top`

## Requirements
- R1: A line's pattern is a 6-bit value/care pair over ir[7:2]. For every bit whose care bit is 1, ir must equal the value bit. Bits whose care bit is 0, and ir[1:0], take no part in the pattern comparison.
- R2: The group signals are g1 = ir[0], g2 = ir[1] and g3 = !ir[0] & !ir[1]. A line's 2-bit group field is 0 for any group, or 1, 2 or 3 for the group it requires. The line fires only if that group signal is high.
- R3: With ir[1:0] = 11, g1 and g2 are both high. At cycle 0, opcode 0xAF fires exactly the union of the lines fired by 0xAD and by 0xAE (16'h203F = 16'h2039 | 16'h002E in the default table).
- R4: A line's 3-bit cycle field of 0..5 fires only when tstate[cycle] is high. The values 6 and 7 mean any cycle.
- R5: Matching uses only the pattern, the group and the cycle, with no notion of instruction length. A cycle-5 line fires for any opcode that matches its pattern and group, even if that instruction is short.
- R6: Two table entries with identical fields always produce identical output bits (default lines 0 and 13).
- R7: Output bit i reports table entry i. In the default table: line 0 is accumulator load (101xxx, group 1, cycle 0), line 1 is X load/store (10xxxx, group 2, any cycle) and line 2 is transfer/X load (101xxx, group 2, cycle 0).
- R8: With REG_OUT=0 the output follows ir and tstate with no clock. With REG_OUT=1 it appears one clock later, and an active-low reset clears it to zero.
- R9: tstate must be one-hot over its six bits. Any other value is outside the contract and is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| ir | input | 8 | Instruction register |
| tstate | input | 6 | One-hot timing state, bit n = cycle n |
| lines | output | NLINES | One bit per decode line, in table order |

## Verification
The hardest case to reach from the ports is the 11 column of the low opcode bits. There the two groups merge, and a fault in only one group term would stay hidden by a normal opcode. The bench drives 0xAD, 0xAE and 0xAF at cycle 0 and checks the exact merged vector. It also sweeps all 256 opcodes across all six cycles against a table-driven reference, so every line meets each group combination. Lines that target cycles a short instruction never reaches are driven directly through the timing input.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int PAT_W   = 6;
  localparam int CYC_N   = 6;
  localparam int DEF_N   = 16;

  localparam logic [1:0] GRP_ANY = 2'd0;
  localparam logic [1:0] GRP_1   = 2'd1;
  localparam logic [1:0] GRP_2   = 2'd2;
  localparam logic [1:0] GRP_3   = 2'd3;
  localparam logic [2:0] CYC_ANY = 3'd7;

  typedef struct packed {
    logic [PAT_W-1:0] val;
    logic [PAT_W-1:0] care;
    logic [1:0]       grp;
    logic [2:0]       cyc;
  } line_t;

  function automatic line_t mk(logic [5:0] v, logic [5:0] c, logic [1:0] g, logic [2:0] t);
    line_t e;
    e.val = v & c; e.care = c; e.grp = g; e.cyc = t;
    return e;
  endfunction

  localparam line_t DEF_TABLE [DEF_N] = '{
    mk(6'b101000, 6'b111000, GRP_1,   3'd0),    // 0  load accumulator
    mk(6'b100000, 6'b110000, GRP_2,   CYC_ANY), // 1  X load/store
    mk(6'b101000, 6'b111000, GRP_2,   3'd0),    // 2  transfer / X load
    mk(6'b000000, 6'b000000, GRP_ANY, 3'd0),    // 3  every opcode, cycle 0
    mk(6'b000000, 6'b000000, GRP_1,   3'd0),    // 4  group 1, cycle 0
    mk(6'b000000, 6'b010000, GRP_ANY, CYC_ANY), // 5  ir[6] low
    mk(6'b100000, 6'b111000, GRP_ANY, CYC_ANY), // 6  store family
    mk(6'b000000, 6'b000000, GRP_ANY, 3'd2),    // 7  every opcode, cycle 2
    mk(6'b101010, 6'b111111, GRP_2,   3'd0),    // 8  A to X transfer
    mk(6'b101010, 6'b111111, GRP_3,   3'd0),    // 9  A to Y transfer
    mk(6'b110000, 6'b111000, GRP_1,   3'd0),    // 10 compare
    mk(6'b100001, 6'b111001, GRP_3,   CYC_ANY), // 11 store Y
    mk(6'b000100, 6'b000111, GRP_1,   3'd5),    // 12 indirect-indexed cycle 5
    mk(6'b101000, 6'b111000, GRP_1,   3'd0),    // 13 copy of line 0
    mk(6'b000000, 6'b111111, GRP_3,   3'd5),    // 14 interrupt cycle 5
    mk(6'b000010, 6'b000010, GRP_ANY, 3'd2)     // 15 absolute modes cycle 2
  };
endpackage

// File: rtl/opdec_grp.sv
module opdec_grp (
  input  logic [1:0] lo,
  output logic [2:0] grp   // bit k = group k+1
);
  always_comb begin
    grp[0] = lo[0];
    grp[1] = lo[1];
    grp[2] = ~lo[0] & ~lo[1];
  end
endmodule

// File: rtl/opdec_line.sv
module opdec_line
  import opdec_pkg::*;
#(
  parameter line_t ENTRY = '0
) (
  input  logic [PAT_W-1:0] pat,
  input  logic [2:0]       grp,
  input  logic [CYC_N-1:0] tstate,
  output logic             hit
);
  logic pat_ok, grp_ok, cyc_ok;

  assign pat_ok = ((pat ^ ENTRY.val) & ENTRY.care) == '0;

  generate
    if (ENTRY.grp == GRP_ANY) begin : g_gany
      assign grp_ok = 1'b1;
    end else begin : g_gsel
      assign grp_ok = grp[ENTRY.grp - 2'd1];
    end
    if (int'(ENTRY.cyc) >= CYC_N) begin : g_cany
      assign cyc_ok = 1'b1;
    end else begin : g_csel
      assign cyc_ok = tstate[ENTRY.cyc];
    end
  endgenerate

  assign hit = pat_ok & grp_ok & cyc_ok;
endmodule

// File: rtl/opdec_oreg.sv
module opdec_oreg #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d;
  end

  assign q = REG_OUT ? q_r : d;
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
#(
  parameter int    NLINES  = DEF_N,
  parameter line_t TABLE [NLINES] = DEF_TABLE,
  parameter bit    REG_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ir,
  input  logic [CYC_N-1:0]  tstate,
  output logic [NLINES-1:0] lines
);
  logic [2:0]        grp;
  logic [NLINES-1:0] raw;

  opdec_grp u_grp (.lo(ir[1:0]), .grp(grp));

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      opdec_line #(.ENTRY(TABLE[i])) u_line (
        .pat(ir[7:2]), .grp(grp), .tstate(tstate), .hit(raw[i])
      );
    end
  endgenerate

  opdec_oreg #(.W(NLINES), .REG_OUT(REG_OUT)) u_oreg (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(lines)
  );
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk
  import opdec_pkg::*;
#(
  parameter int    NLINES  = DEF_N,
  parameter line_t TABLE [NLINES] = DEF_TABLE,
  parameter bit    REG_OUT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ir,
  input logic [CYC_N-1:0]  tstate,
  input logic [NLINES-1:0] lines
);
  logic [7:0]       ir_q;
  logic [CYC_N-1:0] t_q;
  logic [7:0]       ir_s;
  logic [CYC_N-1:0] t_s;

  always_ff @(posedge clk) begin
    ir_q <= ir;
    t_q  <= tstate;
  end
  assign ir_s = REG_OUT ? ir_q : ir;
  assign t_s  = REG_OUT ? t_q  : tstate;

  AST_TSTATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tstate)); // R9

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_c
      AST_PATTERN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        lines[i] |-> (((ir_s[7:2] ^ TABLE[i].val) & TABLE[i].care) == '0)); // R1
      if (TABLE[i].grp == GRP_1) begin : g_g1
        AST_GROUP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
          lines[i] |-> ir_s[0]); // R2
      end
      if (TABLE[i].grp == GRP_2) begin : g_g2
        AST_GROUP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
          lines[i] |-> ir_s[1]); // R2
      end
      if (TABLE[i].grp == GRP_3) begin : g_g3
        AST_GROUP_THREE: assert property (@(posedge clk) disable iff (!rst_n)
          lines[i] |-> (ir_s[1:0] == 2'b00)); // R2
      end
      if (int'(TABLE[i].cyc) < CYC_N) begin : g_cy
        AST_CYCLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
          lines[i] |-> t_s[TABLE[i].cyc]); // R4
      end
      for (genvar j = i + 1; j < NLINES; j++) begin : g_d
        if (TABLE[i] == TABLE[j]) begin : g_same
          AST_DUP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
            lines[i] == lines[j]); // R6
        end
      end
    end
  endgenerate
endmodule

bind opdec_top opdec_chk #(.NLINES(NLINES), .TABLE(TABLE), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ir(ir), .tstate(tstate), .lines(lines)
);

// File: tb/tb_opdec_top.sv
`timescale 1ns/1ps
module tb_opdec_top;
  import opdec_pkg::*;
  localparam int N = DEF_N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ir = 8'h00;
  logic [5:0] tstate = 6'b000001;
  logic [N-1:0] lines, lines_r;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  opdec_top dut (.clk(clk), .rst_n(rst_n), .ir(ir), .tstate(tstate), .lines(lines));
  opdec_top #(.REG_OUT(1'b1)) dut_r (.clk(clk), .rst_n(rst_n), .ir(ir), .tstate(tstate),
                                     .lines(lines_r));

  function automatic logic [N-1:0] ref_lines(logic [7:0] op, int cyc);
    logic [N-1:0] r;
    logic [3:0] g;
    g = {~op[0] & ~op[1], op[1], op[0], 1'b1};
    for (int i = 0; i < N; i++) begin
      r[i] = (((op[7:2] ^ DEF_TABLE[i].val) & DEF_TABLE[i].care) == 6'd0)
           && g[DEF_TABLE[i].grp]
           && (DEF_TABLE[i].cyc > 3'd5 || int'(DEF_TABLE[i].cyc) == cyc);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] op, int cyc);
    ir = op;
    tstate = 6'b1 << cyc;
    #1;
  endtask

  task automatic t_reset;
    chk("R8 reset clears registered output", lines_r, '0);
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 256; op++)
      for (int c = 0; c < 6; c++) begin
        apply(8'(op), c);
        chk("R1 R2 R4 R7 sweep", lines, ref_lines(8'(op), c));
      end
  endtask

  task automatic t_examples;
    apply(8'hAD, 0); chk("R7 0xAD cycle 0", lines, 16'h2039);
    apply(8'hAE, 0); chk("R7 0xAE cycle 0", lines, 16'h002E);
    apply(8'hAE, 3); chk("R7 X load/store any cycle", lines[1], 1'b1);
    apply(8'hAC, 0); chk("R1 low bits 00 vs pattern", lines[2:0], 3'b000);
  endtask

  task automatic t_union;
    logic [N-1:0] a, b;
    apply(8'hAD, 0); a = lines;
    apply(8'hAE, 0); b = lines;
    apply(8'hAF, 0);
    chk("R3 0xAF union", lines, a | b);
    chk("R3 0xAF literal", lines, 16'h203F);
  endtask

  task automatic t_dup;
    for (int op = 0; op < 256; op += 5) begin
      apply(8'(op), 0);
      chk("R6 duplicate lines", lines[13], lines[0]);
    end
  endtask

  task automatic t_late_cycle;
    apply(8'h71, 5); chk("R5 cycle 5 line on short opcode", lines[12], 1'b1);
    apply(8'h00, 5); chk("R5 cycle 5 group 3 line", lines[14], 1'b1);
    apply(8'h00, 4); chk("R4 wrong cycle silent", lines[14], 1'b0);
  endtask

  task automatic t_registered;
    @(negedge clk); ir = 8'hAD; tstate = 6'b000001;
    #0.1 chk("R8 comb output follows input", lines, 16'h2039);
    @(negedge clk); chk("R8 registered one clock later", lines_r, 16'h2039);
    ir = 8'hAE;
    #0.1 chk("R8 registered holds until edge", lines_r, 16'h2039);
    @(negedge clk); chk("R8 registered update", lines_r, 16'h002E);
  endtask

  initial begin
    #7;
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_sweep;
    t_examples;
    t_union;
    t_dup;
    t_late_cycle;
    t_registered;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule